// File: doc/BRIEF.md
# Interconnect Target Agent Register Set

This block is the small control and status register file placed in front of one target on an on-chip peripheral interconnect. It has a simple 32-bit register port with select, write enable, access size, address, write data and read data. An error flag reports every access that is not allowed. Three registers are visible: a fixed identification word, an agent control word and an agent status word.

The status word holds one sticky request-timeout flag. An external one-cycle `timeout_event` pulse sets it. Software clears it by writing a 1 to bit 0 of the control word. That same write also sends a one-cycle reset pulse toward the downstream target.

Only full 32-bit accesses to the three defined offsets are legal. Any other access raises the error flag, has no effect and reads as zero. Responses are registered: read data and the error flag appear in the cycle after the access and are zero in any cycle that follows no access.

Top module: `tgt_agent_regs`

## Requirements
- R1: After reset the control word reads 0x00000200, the status word reads 0x00000000, and `bus_rdata`, `bus_err` and `target_rst` are all 0.
- R2: A 32-bit read at offset 0x00 returns 0x54414754 (ASCII "TAGT", most significant byte first).
- R3: A 32-bit write at offset 0x20 stores only the bits set in 0x01000700. All other bits read back as 0, and bit 0 is never stored.
- R4: A 32-bit write at offset 0x00 or 0x28 changes no register and raises `bus_err` in the response cycle.
- R5: A legal control write with bit 0 set clears the timeout flag (status bit 0, offset 0x28).
- R6: A `timeout_event` pulse sets status bit 0. If that pulse falls in the same cycle as a clearing control write, the flag ends up set.
- R7: A legal control write with bit 0 set drives `target_rst` high for exactly the cycle after the write.
- R8: Any access whose `bus_size` is not 2 (0 means byte, 1 means halfword, 2 means word) raises `bus_err`, reads as 0 and changes no register.
- R9: Any access to an offset other than 0x00, 0x20 or 0x28 raises `bus_err`, reads as 0 and changes no register.
- R10: `bus_rdata` and `bus_err` are registered. They carry the response in the cycle after the access and are 0 after any cycle with `bus_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the access |
| bus_err | output | 1 | Illegal-access flag, one cycle after the access |
| timeout_event | input | 1 | One-cycle pulse that sets the timeout flag |
| target_rst | output | 1 | One-cycle reset pulse toward the target |

## Verification
On every cycle the assertions check the following:
- every reset pulse was caused by a clearing control write;
- a timeout pulse always leaves the flag set, and a clearing write with no pulse always leaves it clear;
- idle cycles give a quiet response;
- a wrong access size always yields an error with zero data;
- the control word moves only on a legal control write;
- writes to read-only offsets always raise the error flag.

Other properties need the bench's scenarios. These are the exact masked value kept by a control write, the identification constant, and the reset values. The bench also confirms that rejected writes left the stored state untouched, by reading it back through the port.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     width_ok;
  } decode_t;

endpackage

// File: rtl/ta_decode.sv
module ta_decode
  import ta_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ID_OFF   = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h28
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output decode_t           dec
);

  always_comb begin
    dec.width_ok = (acc_size_e'(size) == SZ_WORD);
    if (addr == ID_OFF)        dec.sel = SEL_ID;
    else if (addr == CTRL_OFF) dec.sel = SEL_CTRL;
    else if (addr == STAT_OFF) dec.sel = SEL_STAT;
    else                       dec.sel = SEL_NONE;
  end

endmodule

// File: rtl/ta_ctrl_reg.sv
module ta_ctrl_reg #(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] CTRL_MASK  = 32'h0100_0700,
  parameter logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              rst_req
);

  logic [DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    rst_req = 1'b0;
    if (wr_en) begin
      ctrl_d  = wdata & CTRL_MASK;
      rst_req = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/ta_status_reg.sv
module ta_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic tout_q
);

  logic tout_d;
  logic tout_en;

  always_comb begin
    tout_en = set_evt | clr_req;
    tout_d  = set_evt;   // a set in the same cycle as a clear wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tout_q <= 1'b0;
    else if (tout_en) tout_q <= tout_d;
  end

endmodule

// File: rtl/tgt_agent_regs.sv
module tgt_agent_regs
  import ta_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] ID_VALUE   = 32'h5441_4754,
  parameter logic [DATA_W-1:0] CTRL_MASK  = 32'h0100_0700,
  parameter logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0200,
  parameter logic [ADDR_W-1:0] ID_OFF     = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF   = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF   = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              timeout_event,
  output logic              target_rst
);

  decode_t           dec;
  logic              acc_ok;
  logic              ctrl_wr;
  logic              rst_req;
  logic [DATA_W-1:0] ctrl_q;
  logic              tout_q;
  logic [DATA_W-1:0] rdata_d;
  logic              err_d;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              trst_q;

  ta_decode #(
    .ADDR_W  (ADDR_W),
    .ID_OFF  (ID_OFF),
    .CTRL_OFF(CTRL_OFF),
    .STAT_OFF(STAT_OFF)
  ) u_dec (
    .addr(bus_addr),
    .size(bus_size),
    .dec (dec)
  );

  always_comb begin
    acc_ok  = bus_sel && dec.width_ok;
    ctrl_wr = acc_ok && bus_we && (dec.sel == SEL_CTRL);
  end

  ta_ctrl_reg #(
    .DATA_W    (DATA_W),
    .CTRL_MASK (CTRL_MASK),
    .CTRL_RESET(CTRL_RESET)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .rst_req(rst_req)
  );

  ta_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(timeout_event),
    .clr_req(rst_req),
    .tout_q (tout_q)
  );

  // response next-state
  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    if (bus_sel) begin
      if (!dec.width_ok || dec.sel == SEL_NONE) begin
        err_d = 1'b1;
      end else if (bus_we) begin
        err_d = (dec.sel != SEL_CTRL);
      end else begin
        case (dec.sel)
          SEL_ID:   rdata_d = ID_VALUE;
          SEL_CTRL: rdata_d = ctrl_q;
          SEL_STAT: rdata_d = {{(DATA_W-1){1'b0}}, tout_q};
          default:  rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      trst_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
      trst_q  <= rst_req;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign target_rst = trst_q;

endmodule

// File: rtl/tgt_agent_regs_chk.sv
module tgt_agent_regs_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] ID_OFF   = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              timeout_event,
  input logic              target_rst,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              tout_q
);

  logic legal_ctrl_wr;
  logic ro_wr;
  assign legal_ctrl_wr = bus_sel && bus_we && (bus_size == 2'd2) && (bus_addr == CTRL_OFF);
  assign ro_wr = bus_sel && bus_we && (bus_size == 2'd2) &&
                 ((bus_addr == ID_OFF) || (bus_addr == STAT_OFF));

  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    target_rst |-> $past(legal_ctrl_wr && bus_wdata[0]));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timeout_event) |-> tout_q);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(legal_ctrl_wr && bus_wdata[0] && !timeout_event) |-> !tout_q);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel) |-> (bus_rdata == '0 && !bus_err));

  a_r8_width_err: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && bus_size != 2'd2) |-> (bus_err && bus_rdata == '0));

  a_r9_ctrl_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(legal_ctrl_wr) |-> $stable(ctrl_q));

  a_r4_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ro_wr) |-> bus_err);

endmodule

bind tgt_agent_regs tgt_agent_regs_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ID_OFF  (ID_OFF),
  .CTRL_OFF(CTRL_OFF),
  .STAT_OFF(STAT_OFF)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_size     (bus_size),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .timeout_event(timeout_event),
  .target_rst   (target_rst),
  .ctrl_q       (ctrl_q),
  .tout_q       (tout_q)
);

// File: tb/tb_tgt_agent_regs.sv
module tb_tgt_agent_regs;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        timeout_event = 1'b0;
  logic        target_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_ctrl;
  logic        m_tout;
  logic [31:0] e_rdata;
  logic        e_err;
  logic        e_rst;

  tgt_agent_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .timeout_event(timeout_event), .target_rst(target_rst)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h0000_0200; m_tout = 1'b0;
      e_rdata = 32'h0; e_err = 1'b0; e_rst = 1'b0;
    end else begin
      bit clr;
      clr = 0;
      e_rdata = 32'h0; e_err = 1'b0; e_rst = 1'b0;
      if (bus_sel) begin
        if (bus_size != 2'd2) e_err = 1'b1;
        else if (bus_addr == 8'h00) begin
          if (bus_we) e_err = 1'b1; else e_rdata = "TAGT";
        end else if (bus_addr == 8'h20) begin
          if (bus_we) begin
            m_ctrl = bus_wdata & 32'h0100_0700;
            if (bus_wdata[0]) begin clr = 1; e_rst = 1'b1; end
          end else e_rdata = m_ctrl;
        end else if (bus_addr == 8'h28) begin
          if (bus_we) e_err = 1'b1; else e_rdata = {31'h0, m_tout};
        end else e_err = 1'b1;
      end
      if (timeout_event) m_tout = 1'b1;
      else if (clr) m_tout = 1'b0;
    end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== e_rdata || bus_err !== e_err || target_rst !== e_rst) begin
        errors++;
        $display("FAIL %s: rdata=%h err=%b rst=%b expected rdata=%h err=%b rst=%b",
                 cur_req, bus_rdata, bus_err, target_rst, e_rdata, e_err, e_rst);
      end
    end
  end

  task automatic acc(input string rq, input bit we, input logic [7:0] a,
                     input logic [1:0] sz, input logic [31:0] wd, input bit tev);
    @(negedge clk);
    cur_req = rq;
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_size = sz;
    bus_wdata = wd; timeout_event = tev;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; timeout_event = 1'b0;
  endtask

  task automatic pulse_tev(input string rq);
    @(negedge clk);
    cur_req = rq; timeout_event = 1'b1;
    @(negedge clk);
    timeout_event = 1'b0;
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*3);
    // R1: outputs quiet in reset
    checks++;
    if (bus_rdata !== 32'h0 || bus_err !== 1'b0 || target_rst !== 1'b0) begin
      errors++;
      $display("FAIL R1: rdata=%h err=%b rst=%b expected 0 0 0", bus_rdata, bus_err, target_rst);
    end
    @(negedge clk); rst_n = 1'b1;
    acc("R1", 0, 8'h20, 2'd2, 0, 0);
    acc("R1", 0, 8'h28, 2'd2, 0, 0);
    acc("R2", 0, 8'h00, 2'd2, 0, 0);
    acc("R3", 1, 8'h20, 2'd2, 32'hFFFF_FFFE, 0);
    acc("R3", 0, 8'h20, 2'd2, 0, 0);
    acc("R3", 1, 8'h20, 2'd2, 32'h1234_5678, 0);
    acc("R3", 0, 8'h20, 2'd2, 0, 0);
    acc("R4", 1, 8'h00, 2'd2, 32'hDEAD_BEEF, 0);
    acc("R4", 0, 8'h00, 2'd2, 0, 0);
    acc("R4", 1, 8'h28, 2'd2, 32'h0, 0);
    pulse_tev("R6");
    acc("R6", 0, 8'h28, 2'd2, 0, 0);
    acc("R4", 1, 8'h28, 2'd2, 32'h0, 0);
    acc("R4", 0, 8'h28, 2'd2, 0, 0);
    acc("R7", 1, 8'h20, 2'd2, 32'h0000_0101, 0);
    acc("R5", 0, 8'h28, 2'd2, 0, 0);
    acc("R5", 0, 8'h20, 2'd2, 0, 0);
    pulse_tev("R6");
    acc("R6", 1, 8'h20, 2'd2, 32'h0100_0001, 1);
    acc("R6", 0, 8'h28, 2'd2, 0, 0);
    acc("R7", 1, 8'h20, 2'd2, 32'h0000_0001, 0);
    acc("R7", 1, 8'h20, 2'd2, 32'h0000_0001, 0);
    acc("R5", 0, 8'h28, 2'd2, 0, 0);
    for (int s = 0; s < 2; s++) begin
      acc("R8", 1, 8'h20, s[1:0], 32'hFFFF_FFFF, 0);
      acc("R8", 0, 8'h00, s[1:0], 0, 0);
      acc("R8", 0, 8'h20, s[1:0], 0, 0);
    end
    acc("R8", 0, 8'h20, 2'd3, 0, 0);
    acc("R8", 0, 8'h20, 2'd2, 0, 0);
    pulse_tev("R8");
    acc("R8", 1, 8'h28, 2'd0, 32'h1, 0);
    acc("R8", 1, 8'h20, 2'd1, 32'h1, 0);
    acc("R8", 0, 8'h28, 2'd2, 0, 0);
    acc("R9", 0, 8'h04, 2'd2, 0, 0);
    acc("R9", 0, 8'h21, 2'd2, 0, 0);
    acc("R9", 1, 8'h24, 2'd2, 32'hFFFF_FFFF, 0);
    acc("R9", 1, 8'hFC, 2'd2, 32'h0000_0001, 0);
    acc("R9", 0, 8'h20, 2'd2, 0, 0);
    acc("R9", 0, 8'h28, 2'd2, 0, 0);
    cur_req = "R10";
    repeat (4) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule